// File: doc/BRIEF.md
# I2C Command Script Encoder

This block turns a stream of I2C message descriptors into a packed script of 4-bit bit-level commands for a separate bus sequencer. Each descriptor carries a 7-bit target address, a read/write flag, a byte length, the bytes to be written and a flag that closes the transfer. For every message the encoder emits a start pattern and the address byte, followed by either the write-data patterns or the read patterns. Consecutive messages are joined by repeated starts. A single stop pattern follows the last message, and one or two end commands close the script so that its command count is even.

The encoder produces one command per clock. It packs two commands into each byte and writes that byte into an external command memory through a plain write port. When the script is complete it pulses `done` and presents the total command count. Descriptors are accepted through a valid/ready handshake. A descriptor marked void adds no commands, which is how a transfer with zero messages, or a transfer that is closed late, is expressed.

Top module: `i2c_script_enc`

## Requirements
- R1: After reset `desc_ready` is 1, `done` is 0 and no memory write occurs. A descriptor is taken only while `desc_ready` is 1, and `desc_ready` is 0 while commands are being produced or while `done` is high.
- R2: Each message begins with a start pattern of four commands: 0x5 (data high), 0x3 (clock high), 0x4 (data low), 0x2 (clock low).
- R3: A written byte is eight commands, MSB first, with 0xC for a 1 bit and 0x8 for a 0 bit, followed by 0xE (expect ACK low). The address byte of each message is written this way, with the value (address << 1) | read flag.
- R4: A read byte is eight 0xD commands followed by one acknowledge command. That command is 0x8 for every byte except the last byte of the message, which gets 0xC.
- R5: The stop pattern 0x4 (data low), 0x3 (clock high), 0x5 (data high) appears once, after the last message only. Messages before it are followed directly by the next start.
- R6: After the stop comes one end command 0x0, plus a second 0x0 if the count would otherwise be odd. The count reported with `done` is always even.
- R7: Command k of the script goes into byte k/2 of the memory. An even k fills the low nibble and an odd k fills the high nibble. A byte is written only in the cycle after its odd command is produced.
- R8: A byte whose index is MEM_BYTES or more is not written, but its commands still count toward the reported total.
- R9: `done` is high for one cycle with `cmd_count` equal to the number of commands in the script. The count restarts from 0 for the next transfer.
- R10: A void descriptor adds no commands. A void descriptor that closes a transfer with no messages gives `done` with count 0 and no memory write.
- R11: The length of a write message is limited to MAX_LEN bytes. A longer length produces exactly MAX_LEN data bytes, taken from `desc_wdata` with byte 0 in bits [7:0] sent first.
- R12: A message of length 0 produces only its start pattern and its address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken this cycle |
| desc_addr | input | 7 | 7-bit target address |
| desc_rd | input | 1 | 1 = read message, 0 = write message |
| desc_len | input | LEN_W | Message length in bytes |
| desc_wdata | input | MAX_LEN*8 | Write bytes, byte 0 in bits [7:0] |
| desc_last | input | 1 | Descriptor closes the transfer |
| desc_void | input | 1 | Descriptor adds no message |
| mem_we | output | 1 | Command memory write strobe |
| mem_addr | output | $clog2(MEM_BYTES) | Command memory byte address |
| mem_wdata | output | 8 | Packed command pair, odd command in the high nibble |
| done | output | 1 | One-cycle pulse at the end of a script |
| cmd_count | output | CNT_W | Total command count, valid while `done` is high |

## Verification
Two events can meet in one cycle: the end of one script and the offer of the next descriptor. To provoke this, the bench keeps the next descriptor valid while `done` is pulsing. It then checks that the new descriptor is not taken in the `done` cycle, and that the following script reports a count starting from zero. A second meeting point is the write of the last in-range byte next to the first dropped byte. A long read script crosses the memory end, and the bench compares the number of writes and the kept contents against its own model.

// File: rtl/scr_pkg.sv
package scr_pkg;

   // bit-level sequencer commands (4-bit codes seen by the sequencer)
   typedef enum logic [3:0] {
      CMD_END    = 4'h0,
      CMD_CLK_LO = 4'h2,
      CMD_CLK_HI = 4'h3,
      CMD_DAT_LO = 4'h4,
      CMD_DAT_HI = 4'h5,
      CMD_BIT_0  = 4'h8,
      CMD_BIT_1  = 4'hC,
      CMD_SAMPLE = 4'hD,
      CMD_ACK_LO = 4'hE
   } scr_cmd_e;

   typedef enum logic [2:0] {
      GS_IDLE,
      GS_START,
      GS_ADDR,
      GS_DATA,
      GS_STOP,
      GS_END1,
      GS_END2,
      GS_DONE
   } scr_state_e;

endpackage

// File: rtl/scr_byte_cmd.sv
module scr_byte_cmd
   import scr_pkg::*;
(
   input  logic [3:0] step,
   input  logic [7:0] value,
   input  logic       is_read,
   input  logic       final_rd,
   output logic [3:0] code
);

   logic [2:0] bit_sel;
   assign bit_sel = 3'd7 - step[2:0];

   always_comb begin
      if (step[3]) begin
         if (is_read) code = final_rd ? CMD_BIT_1 : CMD_BIT_0;
         else         code = CMD_ACK_LO;
      end else if (is_read) begin
         code = CMD_SAMPLE;
      end else begin
         code = value[bit_sel] ? CMD_BIT_1 : CMD_BIT_0;
      end
   end

endmodule

// File: rtl/scr_nibble_packer.sv
module scr_nibble_packer #(
   parameter int MEM_BYTES = 64,
   parameter int CNT_W     = 12,
   localparam int AW       = $clog2(MEM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_code,
   input  logic             clr,
   output logic             cnt_odd,
   output logic [CNT_W-1:0] cnt,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [7:0]       mem_wdata
);

   initial begin
      if (MEM_BYTES < 2) $error("MEM_BYTES must be at least 2");
      if (CNT_W - 1 <= AW) $error("CNT_W too narrow for MEM_BYTES");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       low_q;
   logic [CNT_W-2:0] pair_idx;
   logic             in_range;

   assign pair_idx = cnt_q[CNT_W-1:1];
   assign in_range = pair_idx < (CNT_W-1)'(MEM_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         low_q     <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         if (clr) begin
            cnt_q <= '0;
         end else if (cmd_valid) begin
            if (!cnt_q[0]) begin
               low_q <= cmd_code;
            end else if (in_range) begin
               mem_we    <= 1'b1;
               mem_addr  <= pair_idx[AW-1:0];
               mem_wdata <= {cmd_code, low_q};
            end
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt     = cnt_q;
   assign cnt_odd = cnt_q[0];

   // R7
   pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !cnt_q[0]);

endmodule

// File: rtl/scr_pattern_gen.sv
module scr_pattern_gen
   import scr_pkg::*;
#(
   parameter int LEN_W   = 4,
   parameter int MAX_LEN = 4,
   localparam int IW     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 desc_valid,
   output logic                 desc_ready,
   input  logic [6:0]           desc_addr,
   input  logic                 desc_rd,
   input  logic [LEN_W-1:0]     desc_len,
   input  logic [MAX_LEN*8-1:0] desc_wdata,
   input  logic                 desc_last,
   input  logic                 desc_void,
   input  logic                 cnt_odd,
   output logic                 cmd_valid,
   output logic [3:0]           cmd_code,
   output logic                 done,
   output logic                 clr
);

   initial begin
      if (MAX_LEN < 2) $error("MAX_LEN must be at least 2");
      if (MAX_LEN >= (1 << LEN_W)) $error("LEN_W too narrow for MAX_LEN");
   end

   scr_state_e           state_q;
   logic [3:0]           step_q;
   logic [LEN_W-1:0]     idx_q;
   logic [LEN_W-1:0]     len_q;
   logic [7:0]           addr_byte_q;
   logic                 rd_q;
   logic                 last_q;
   logic                 any_msg_q;
   logic [MAX_LEN*8-1:0] wdata_q;
   logic [7:0]           wbytes [MAX_LEN];

   for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_unpack
      assign wbytes[gi] = wdata_q[gi*8 +: 8];
   end

   logic       accept;
   logic       byte_end;
   logic       msg_end;
   logic [7:0] cur_byte;
   logic       cur_read;
   logic       final_byte;
   logic [3:0] byte_code;

   assign desc_ready = (state_q == GS_IDLE);
   assign accept     = desc_valid && desc_ready;
   assign final_byte = (idx_q + LEN_W'(1)) == len_q;
   assign byte_end   = step_q == 4'd8;
   assign cur_byte   = (state_q == GS_ADDR) ? addr_byte_q : wbytes[idx_q[IW-1:0]];
   assign cur_read   = (state_q == GS_DATA) && rd_q;
   assign msg_end    = byte_end && (((state_q == GS_ADDR) && (len_q == '0)) ||
                                    ((state_q == GS_DATA) && final_byte));

   scr_byte_cmd u_byte (
      .step     (step_q),
      .value    (cur_byte),
      .is_read  (cur_read),
      .final_rd (final_byte),
      .code     (byte_code)
   );

   always_comb begin
      cmd_valid = 1'b0;
      cmd_code  = CMD_END;
      unique case (state_q)
         GS_START: begin
            cmd_valid = 1'b1;
            case (step_q[1:0])
               2'd0:    cmd_code = CMD_DAT_HI;
               2'd1:    cmd_code = CMD_CLK_HI;
               2'd2:    cmd_code = CMD_DAT_LO;
               default: cmd_code = CMD_CLK_LO;
            endcase
         end
         GS_ADDR, GS_DATA: begin
            cmd_valid = 1'b1;
            cmd_code  = byte_code;
         end
         GS_STOP: begin
            cmd_valid = 1'b1;
            case (step_q[1:0])
               2'd0:    cmd_code = CMD_DAT_LO;
               2'd1:    cmd_code = CMD_CLK_HI;
               default: cmd_code = CMD_DAT_HI;
            endcase
         end
         GS_END1: cmd_valid = 1'b1;
         GS_END2: cmd_valid = cnt_odd;
         default: ;
      endcase
   end

   assign done = (state_q == GS_DONE);
   assign clr  = done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= GS_IDLE;
         step_q      <= '0;
         idx_q       <= '0;
         len_q       <= '0;
         addr_byte_q <= '0;
         rd_q        <= 1'b0;
         last_q      <= 1'b0;
         any_msg_q   <= 1'b0;
         wdata_q     <= '0;
      end else begin
         unique case (state_q)
            GS_IDLE: if (accept) begin
               step_q <= '0;
               idx_q  <= '0;
               if (desc_void) begin
                  if (desc_last) state_q <= any_msg_q ? GS_STOP : GS_DONE;
               end else begin
                  addr_byte_q <= {desc_addr, desc_rd};
                  rd_q        <= desc_rd;
                  last_q      <= desc_last;
                  wdata_q     <= desc_wdata;
                  any_msg_q   <= 1'b1;
                  len_q       <= (!desc_rd && desc_len > LEN_W'(MAX_LEN)) ?
                                 LEN_W'(MAX_LEN) : desc_len;
                  state_q     <= GS_START;
               end
            end
            GS_START: begin
               step_q <= step_q + 1'b1;
               if (step_q == 4'd3) begin
                  step_q  <= '0;
                  state_q <= GS_ADDR;
               end
            end
            GS_ADDR, GS_DATA: begin
               step_q <= step_q + 1'b1;
               if (byte_end) begin
                  step_q <= '0;
                  if (msg_end) begin
                     state_q <= last_q ? GS_STOP : GS_IDLE;
                  end else if (state_q == GS_ADDR) begin
                     idx_q   <= '0;
                     state_q <= GS_DATA;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            GS_STOP: begin
               step_q <= step_q + 1'b1;
               if (step_q == 4'd2) begin
                  step_q  <= '0;
                  state_q <= GS_END1;
               end
            end
            GS_END1: state_q <= GS_END2;
            GS_END2: state_q <= GS_DONE;
            GS_DONE: begin
               any_msg_q <= 1'b0;
               state_q   <= GS_IDLE;
            end
            default: state_q <= GS_IDLE;
         endcase
      end
   end

   // R1
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !desc_ready);

endmodule

// File: rtl/i2c_script_enc.sv
module i2c_script_enc #(
   parameter int MEM_BYTES = 64,
   parameter int CNT_W     = 12,
   parameter int LEN_W     = 4,
   parameter int MAX_LEN   = 4,
   localparam int AW       = $clog2(MEM_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 desc_valid,
   output logic                 desc_ready,
   input  logic [6:0]           desc_addr,
   input  logic                 desc_rd,
   input  logic [LEN_W-1:0]     desc_len,
   input  logic [MAX_LEN*8-1:0] desc_wdata,
   input  logic                 desc_last,
   input  logic                 desc_void,
   output logic                 mem_we,
   output logic [AW-1:0]        mem_addr,
   output logic [7:0]           mem_wdata,
   output logic                 done,
   output logic [CNT_W-1:0]     cmd_count
);

   logic       cmd_valid;
   logic [3:0] cmd_code;
   logic       cnt_odd;
   logic       clr;

   scr_pattern_gen #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_valid (desc_valid),
      .desc_ready (desc_ready),
      .desc_addr  (desc_addr),
      .desc_rd    (desc_rd),
      .desc_len   (desc_len),
      .desc_wdata (desc_wdata),
      .desc_last  (desc_last),
      .desc_void  (desc_void),
      .cnt_odd    (cnt_odd),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .done       (done),
      .clr        (clr)
   );

   scr_nibble_packer #(.MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .clr       (clr),
      .cnt_odd   (cnt_odd),
      .cnt       (cmd_count),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   // R6
   even_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_count[0]);

   // R1
   done_blocks_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !desc_ready);

   // R9
   count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cmd_count == '0));

endmodule

// File: tb/i2c_script_enc_bench.sv
module i2c_script_enc_bench;

   localparam int MEM_BYTES = 64;
   localparam int CNT_W     = 12;
   localparam int LEN_W     = 4;
   localparam int MAX_LEN   = 4;
   localparam int AW        = $clog2(MEM_BYTES);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 desc_valid = 1'b0;
   logic                 desc_ready;
   logic [6:0]           desc_addr = '0;
   logic                 desc_rd = 1'b0;
   logic [LEN_W-1:0]     desc_len = '0;
   logic [MAX_LEN*8-1:0] desc_wdata = '0;
   logic                 desc_last = 1'b0;
   logic                 desc_void = 1'b0;
   logic                 mem_we;
   logic [AW-1:0]        mem_addr;
   logic [7:0]           mem_wdata;
   logic                 done;
   logic [CNT_W-1:0]     cmd_count;

   always #5 clk = ~clk;

   i2c_script_enc #(.MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W), .LEN_W(LEN_W),
                    .MAX_LEN(MAX_LEN)) u_i2c_script_enc (.*);

   int n_vec  = 0;
   int n_fail = 0;

   int exp_cmd [512];
   int exp_n;
   logic [7:0] cap [MEM_BYTES];
   int cap_writes;
   int got_count;

   always @(negedge clk) begin
      if (mem_we) begin
         cap[mem_addr] <= mem_wdata;
         cap_writes    <= cap_writes + 1;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- reference model of the script ----------------
   task automatic m_put(input int c);
      exp_cmd[exp_n] = c;
      exp_n++;
   endtask

   task automatic m_start();
      m_put(5); m_put(3); m_put(4); m_put(2);
   endtask

   task automatic m_wbyte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) m_put(b[i] ? 12 : 8);
      m_put(14);
   endtask

   task automatic m_rbytes(input int len);
      for (int k = 0; k < len; k++) begin
         for (int i = 0; i < 8; i++) m_put(13);
         m_put((k == len - 1) ? 12 : 8);
      end
   endtask

   task automatic m_tail();
      m_put(4); m_put(3); m_put(5);
      m_put(0);
      if (exp_n % 2) m_put(0);
   endtask

   task automatic m_msg(input logic [6:0] a, input logic rd, input int len,
                        input logic [MAX_LEN*8-1:0] wd);
      m_start();
      m_wbyte({a, rd});
      if (rd) m_rbytes(len);
      else for (int k = 0; k < len; k++) m_wbyte(wd[k*8 +: 8]);
   endtask

   task automatic begin_xfer();
      exp_n = 0;
      cap_writes = 0;
      for (int i = 0; i < MEM_BYTES; i++) cap[i] = 8'hxx;
   endtask

   task automatic send(input logic [6:0] a, input logic rd, input int len,
                       input logic [MAX_LEN*8-1:0] wd, input logic last,
                       input logic vd);
      @(negedge clk);
      desc_valid = 1'b1; desc_addr = a; desc_rd = rd; desc_len = LEN_W'(len);
      desc_wdata = wd; desc_last = last; desc_void = vd;
      while (!desc_ready) @(negedge clk);
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      got_count = int'(cmd_count);
      @(negedge clk);
   endtask

   task automatic judge(input string req);
      int nb;
      int bad;
      nb  = exp_n / 2;
      if (nb > MEM_BYTES) nb = MEM_BYTES;
      bad = -1;
      check(req, got_count, exp_n);
      check(req, cap_writes, nb);
      for (int i = 0; i < nb; i++)
         if (bad < 0 && cap[i] !== 8'((exp_cmd[2*i+1] << 4) | exp_cmd[2*i])) bad = i;
      if (bad >= 0)
         check(req, int'(cap[bad]), (exp_cmd[2*bad+1] << 4) | exp_cmd[2*bad]);
      else
         check(req, 0, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      // R1: idle state after reset
      check("R1 ready", int'(desc_ready), 1);
      check("R1 done", int'(done), 0);
      check("R1 no write", int'(mem_we), 0);
   endtask

   task automatic t_single_write();
      // R2 R3 R5 R6 R7: one write message of 2 bytes, 35 commands padded to 36
      begin_xfer();
      m_msg(7'h50, 1'b0, 2, 32'h0000_A53C); m_tail();
      send(7'h50, 1'b0, 2, 32'h0000_A53C, 1'b1, 1'b0);
      wait_done();
      judge("R2_R3_R6 write");
      check("R6 pad count", got_count, 36);
   endtask

   task automatic t_single_read();
      // R4 R6: read of 3 bytes, 44 commands, no pad
      begin_xfer();
      m_msg(7'h21, 1'b1, 3, '0); m_tail();
      send(7'h21, 1'b1, 3, '0, 1'b1, 1'b0);
      wait_done();
      judge("R4 read");
      check("R6 no pad count", got_count, 44);
   endtask

   task automatic t_write_then_read();
      // R5: repeated start between messages, a single stop
      begin_xfer();
      m_msg(7'h3B, 1'b0, 1, 32'h0000_0081);
      m_msg(7'h3B, 1'b1, 2, '0); m_tail();
      send(7'h3B, 1'b0, 1, 32'h0000_0081, 1'b0, 1'b0);
      send(7'h3B, 1'b1, 2, '0, 1'b1, 1'b0);
      wait_done();
      judge("R5 repeated start");
   endtask

   task automatic t_zero_msgs();
      // R10: void closing descriptor with no message
      begin_xfer();
      send(7'h00, 1'b0, 0, '0, 1'b1, 1'b1);
      wait_done();
      judge("R10 empty");
   endtask

   task automatic t_void_mid();
      // R10: void non-closing descriptor between messages adds nothing;
      // closing void after a message still adds the stop and end
      begin_xfer();
      m_msg(7'h12, 1'b0, 1, 32'h0000_00FF);
      m_msg(7'h13, 1'b0, 1, 32'h0000_0000); m_tail();
      send(7'h12, 1'b0, 1, 32'h0000_00FF, 1'b0, 1'b0);
      send(7'h7F, 1'b1, 9, '0, 1'b0, 1'b1);
      send(7'h13, 1'b0, 1, 32'h0000_0000, 1'b0, 1'b0);
      send(7'h00, 1'b0, 0, '0, 1'b1, 1'b1);
      wait_done();
      judge("R10 void ignored");
   endtask

   task automatic t_zero_len();
      // R12: zero-length message is start plus address only
      begin_xfer();
      m_msg(7'h44, 1'b0, 0, '0); m_tail();
      send(7'h44, 1'b0, 0, 32'hFFFF_FFFF, 1'b1, 1'b0);
      wait_done();
      judge("R12 zero length");
      check("R12 count", got_count, 18);
   endtask

   task automatic t_clamp();
      // R11: write length 6 with MAX_LEN 4 sends 4 data bytes
      begin_xfer();
      m_msg(7'h2A, 1'b0, 4, 32'hDEAD_BEEF); m_tail();
      send(7'h2A, 1'b0, 6, 32'hDEAD_BEEF, 1'b1, 1'b0);
      wait_done();
      judge("R11 clamp");
   endtask

   task automatic t_overflow();
      // R8: 15-byte read gives 152 commands; 76 bytes, only 64 written
      begin_xfer();
      m_msg(7'h55, 1'b1, 15, '0); m_tail();
      send(7'h55, 1'b1, 15, '0, 1'b1, 1'b0);
      wait_done();
      judge("R8 overflow");
      check("R8 total", got_count, 152);
   endtask

   task automatic t_back_to_back();
      // R9 R1: next descriptor held valid while done pulses; count restarts
      begin_xfer();
      m_msg(7'h01, 1'b0, 1, 32'h0000_0055); m_tail();
      send(7'h01, 1'b0, 1, 32'h0000_0055, 1'b1, 1'b0);
      @(negedge clk);
      desc_valid = 1'b1; desc_addr = 7'h02; desc_rd = 1'b1; desc_len = 4'd1;
      desc_wdata = '0; desc_last = 1'b1; desc_void = 1'b0;
      while (!done) @(negedge clk);
      got_count = int'(cmd_count);
      check("R1 not ready at done", int'(desc_ready), 0);
      @(negedge clk);
      @(negedge clk);
      desc_valid = 1'b0;
      judge("R9 first");
      begin_xfer();
      m_msg(7'h02, 1'b1, 1, '0); m_tail();
      wait_done();
      judge("R9 second");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_write();
      t_single_read();
      t_write_then_read();
      t_zero_msgs();
      t_void_mid();
      t_zero_len();
      t_clamp();
      t_overflow();
      t_back_to_back();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule